// File: doc/BRIEF.md
# VLAN Table Command Engine

This block keeps the VLAN table of an 8-port switch: sixteen entries, each with a port member mask, a valid flag, a tag-enable flag, an independent-learning flag, a 2-bit egress code per port and a 12-bit VLAN ID. Software reaches the membership and egress fields only indirectly. It fills two data words, writes a command word that names an operation and an entry, and polls a busy bit. A read command copies the chosen entry into the data words. A write command copies the data words into the entry. The VLAN IDs sit in directly addressed registers that hold two IDs each.

The host side is a plain 32-bit register bus with a single-cycle write strobe and a combinational read path. A separate lookup port returns every stored field of any entry at once, for use by forwarding logic elsewhere on the chip.

The command sequencer is a four-state machine:
- `S_IDLE`: accepts a start.
- `S_DECODE`: the first busy cycle.
- `S_ACCESS`: the table is written, or the data words are loaded.
- `S_HOLD`: pads the operation to a fixed length.

Its transitions are:
- IDLE→DECODE on a command write with the go bit set.
- DECODE→ACCESS unconditionally.
- ACCESS→HOLD unconditionally.
- HOLD→HOLD until the busy counter reaches BUSY_CYCLES−1.
- HOLD→IDLE once the counter reaches BUSY_CYCLES−1.

Top module: `vlan_cmd_engine`

Register offsets (byte addresses on `host_addr`):

| Offset | Register |
|---|---|
| 0x000 | Command |
| 0x004 | Data word A |
| 0x008 | Data word B |
| 0x100 + 4·(e/2) | VLAN ID pair for entries e and e+1 |

## Requirements
- R1: A write to the command register with bit 31 set while idle starts an operation. Bit 31 of the command register then reads 1 for exactly BUSY_CYCLES (4) clock cycles and afterwards reads 0. A command write with bit 31 clear starts nothing.
- R2: The command register reads back the accepted operation code in bits 14:12 and the entry index in bits 11:0.
- R3: Operation code 1 (write) copies data word A into the entry: valid from bit 0, member mask from bits 23:16, tag-enable from bit 28, independent-learning from bit 30. The change shows on the lookup outputs once busy has cleared.
- R4: Operation code 0 (read) loads data word A from the entry, with the same bit positions as in R3 and every other bit 0. It also loads data word B with the entry's egress codes.
- R5: Data word B holds a 2-bit egress code for port p at bits 2p+1:2p (0 untag, 1 swap, 2 tag, 3 stack). A write command stores these codes unchanged, and bits above 2×NUM_PORTS read back as 0.
- R6: A write command issued with data word A all zero leaves the entry invalid, with an empty member mask.
- R7: The VLAN ID register at 0x100+4k holds the ID of entry 2k in bits 11:0 and the ID of entry 2k+1 in bits 23:12. A write sets both IDs. Bits 31:24 read 0. Other pairs are not affected.
- R8: A command write that arrives while busy is ignored. The operation in flight, the command readback and the table are unaffected.
- R9: An entry index of 16 or more completes in the same BUSY_CYCLES without changing any entry. A read with such an index returns zero in both data words.
- R10: After reset every entry is invalid, each entry's VLAN ID equals its index, the data words and command register read 0, and busy is clear.
- R11: An operation code other than 0 or 1 runs for the normal busy time and changes neither the table nor the data words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_we | input | 1 | Register write strobe, one cycle per write |
| host_addr | input | 12 | Register byte address |
| host_wdata | input | 32 | Register write data |
| host_rdata | output | 32 | Read data for host_addr (combinational) |
| lk_idx | input | 4 | Entry selected on the lookup port |
| lk_valid | output | 1 | Valid flag of the selected entry |
| lk_members | output | 8 | Port member mask of the selected entry |
| lk_tag_en | output | 1 | Tag-enable flag of the selected entry |
| lk_ivl | output | 1 | Independent-learning flag of the selected entry |
| lk_egress | output | 16 | Packed 2-bit egress codes of the selected entry |
| lk_vid | output | 12 | VLAN ID of the selected entry |

## Verification
The bench builds the block with its default parameters: 8 ports, 16 entries, 12-bit IDs, a 4-cycle busy window and a 12-bit address. With these values the 12-bit index field can name entries beyond the end of the table, and the busy window is short enough to count cycle by cycle. Each of the eight ID pair registers can also be compared against the lookup port. The full-width member mask and egress word let stray bits written above the stored fields be seen to read back as zero.

// File: rtl/vct_pkg.sv
package vct_pkg;
    typedef enum logic [1:0] {
        S_IDLE,
        S_DECODE,
        S_ACCESS,
        S_HOLD
    } vct_state_e;

    localparam int VCT_OP_W   = 3;
    localparam int VCT_OP_LSB = 12;
    localparam int VCT_IDX_W  = 12;
    localparam int VCT_GO_BIT = 31;

    localparam logic [VCT_OP_W-1:0] VCT_OP_READ  = 3'd0;
    localparam logic [VCT_OP_W-1:0] VCT_OP_WRITE = 3'd1;

    localparam int VCT_B_VALID   = 0;
    localparam int VCT_B_MEMBERS = 16;
    localparam int VCT_B_TAGEN   = 28;
    localparam int VCT_B_IVL     = 30;

    localparam int VCT_OFF_CMD  = 'h000;
    localparam int VCT_OFF_DWA  = 'h004;
    localparam int VCT_OFF_DWB  = 'h008;
    localparam int VCT_VID_BASE = 'h100;
endpackage

// File: rtl/vct_ctrl.sv
module vct_ctrl
    import vct_pkg::*;
#(
    parameter int NUM_ENTRIES = 16,
    parameter int BUSY_CYCLES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 go,
    input  logic [VCT_OP_W-1:0]  go_op,
    input  logic [VCT_IDX_W-1:0] go_idx,
    output logic                 busy,
    output logic [VCT_OP_W-1:0]  op_q,
    output logic [VCT_IDX_W-1:0] idx_q,
    output logic                 idx_ok,
    output logic                 tbl_we,
    output logic                 dw_load
);
    localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(BUSY_CYCLES - 1);

    vct_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (go) state_d = S_DECODE;
            S_DECODE: state_d = S_ACCESS;
            S_ACCESS: state_d = S_HOLD;
            S_HOLD:   if (cnt_q == LAST_CNT) state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q  <= '0;
            idx_q <= '0;
            cnt_q <= '0;
        end else if (state_q == S_IDLE) begin
            if (go) begin
                op_q  <= go_op;
                idx_q <= go_idx;
                cnt_q <= '0;
            end
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        busy    = (state_q != S_IDLE);
        idx_ok  = (idx_q < VCT_IDX_W'(NUM_ENTRIES));
        tbl_we  = (state_q == S_ACCESS) && (op_q == VCT_OP_WRITE) && idx_ok;
        dw_load = (state_q == S_ACCESS) && (op_q == VCT_OP_READ);
    end

    // R1
    start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (go && !busy) |=> busy);
    // R1
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cnt_q < CNT_W'(BUSY_CYCLES)));
    // R8
    cmd_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(op_q) && $stable(idx_q)));
    // R3
    access_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tbl_we, dw_load}));
endmodule

// File: rtl/vct_store.sv
module vct_store #(
    parameter int NUM_ENTRIES = 16,
    parameter int NUM_PORTS   = 8,
    localparam int IDX_W      = $clog2(NUM_ENTRIES),
    localparam int EGR_W      = 2 * NUM_PORTS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [IDX_W-1:0]     wr_idx,
    input  logic                 wr_valid,
    input  logic [NUM_PORTS-1:0] wr_members,
    input  logic                 wr_tag_en,
    input  logic                 wr_ivl,
    input  logic [EGR_W-1:0]     wr_egress,
    input  logic [IDX_W-1:0]     rd_idx,
    output logic                 rd_valid,
    output logic [NUM_PORTS-1:0] rd_members,
    output logic                 rd_tag_en,
    output logic                 rd_ivl,
    output logic [EGR_W-1:0]     rd_egress,
    input  logic [IDX_W-1:0]     lk_idx,
    output logic                 lk_valid,
    output logic [NUM_PORTS-1:0] lk_members,
    output logic                 lk_tag_en,
    output logic                 lk_ivl,
    output logic [EGR_W-1:0]     lk_egress
);
    logic [NUM_ENTRIES-1:0] valid_q, tag_q, ivl_q;
    logic [NUM_PORTS-1:0]   mem_q [NUM_ENTRIES];
    logic [EGR_W-1:0]       egr_q [NUM_ENTRIES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
            tag_q   <= '0;
            ivl_q   <= '0;
            for (int e = 0; e < NUM_ENTRIES; e++) begin
                mem_q[e] <= '0;
                egr_q[e] <= '0;
            end
        end else if (we) begin
            valid_q[wr_idx] <= wr_valid;
            tag_q[wr_idx]   <= wr_tag_en;
            ivl_q[wr_idx]   <= wr_ivl;
            mem_q[wr_idx]   <= wr_members;
            egr_q[wr_idx]   <= wr_egress;
        end
    end

    always_comb begin
        rd_valid   = valid_q[rd_idx];
        rd_members = mem_q[rd_idx];
        rd_tag_en  = tag_q[rd_idx];
        rd_ivl     = ivl_q[rd_idx];
        rd_egress  = egr_q[rd_idx];
        lk_valid   = valid_q[lk_idx];
        lk_members = mem_q[lk_idx];
        lk_tag_en  = tag_q[lk_idx];
        lk_ivl     = ivl_q[lk_idx];
        lk_egress  = egr_q[lk_idx];
    end

    // R6
    invalid_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !wr_valid) |=> !valid_q[$past(wr_idx)]);
endmodule

// File: rtl/vct_vid_bank.sv
module vct_vid_bank #(
    parameter int NUM_ENTRIES = 16,
    parameter int VID_W       = 12,
    localparam int IDX_W      = $clog2(NUM_ENTRIES),
    localparam int NPAIRS     = NUM_ENTRIES / 2,
    localparam int PAIR_W     = (NPAIRS > 1) ? $clog2(NPAIRS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [PAIR_W-1:0]  pair,
    input  logic [2*VID_W-1:0] wdata,
    output logic [2*VID_W-1:0] rdata,
    input  logic [IDX_W-1:0]   lk_idx,
    output logic [VID_W-1:0]   lk_vid
);
    logic [VID_W-1:0] vid_q [NUM_ENTRIES];

    for (genvar p = 0; p < NPAIRS; p++) begin : g_pair
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                vid_q[2*p]   <= VID_W'(2*p);
                vid_q[2*p+1] <= VID_W'(2*p+1);
            end else if (we && (pair == PAIR_W'(p))) begin
                vid_q[2*p]   <= wdata[VID_W-1:0];
                vid_q[2*p+1] <= wdata[2*VID_W-1:VID_W];
            end
        end
    end

    always_comb begin
        rdata  = {vid_q[{pair, 1'b1}], vid_q[{pair, 1'b0}]};
        lk_vid = vid_q[lk_idx];
    end

    // R7
    vid_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (vid_q[{$past(pair), 1'b0}] == $past(wdata[VID_W-1:0])));
endmodule

// File: rtl/vlan_cmd_engine.sv
module vlan_cmd_engine
    import vct_pkg::*;
#(
    parameter int NUM_PORTS   = 8,
    parameter int NUM_ENTRIES = 16,
    parameter int VID_W       = 12,
    parameter int BUSY_CYCLES = 4,
    parameter int ADDR_W      = 12,
    localparam int IDX_W      = $clog2(NUM_ENTRIES),
    localparam int EGR_W      = 2 * NUM_PORTS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 host_we,
    input  logic [ADDR_W-1:0]    host_addr,
    input  logic [31:0]          host_wdata,
    output logic [31:0]          host_rdata,
    input  logic [IDX_W-1:0]     lk_idx,
    output logic                 lk_valid,
    output logic [NUM_PORTS-1:0] lk_members,
    output logic                 lk_tag_en,
    output logic                 lk_ivl,
    output logic [EGR_W-1:0]     lk_egress,
    output logic [VID_W-1:0]     lk_vid
);
    localparam int NPAIRS = NUM_ENTRIES / 2;
    localparam int PAIR_W = (NPAIRS > 1) ? $clog2(NPAIRS) : 1;
    localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(VCT_OFF_CMD);
    localparam logic [ADDR_W-1:0] A_DWA  = ADDR_W'(VCT_OFF_DWA);
    localparam logic [ADDR_W-1:0] A_DWB  = ADDR_W'(VCT_OFF_DWB);
    localparam logic [ADDR_W-1:0] A_VID  = ADDR_W'(VCT_VID_BASE);
    localparam logic [ADDR_W-1:0] A_VEND = ADDR_W'(VCT_VID_BASE + 4 * NPAIRS);

    logic                 go, busy, idx_ok, tbl_we, dw_load;
    logic [VCT_OP_W-1:0]  op_q;
    logic [VCT_IDX_W-1:0] idx_q;
    logic [31:0]          dwa_q, dwb_q, rd_word_a;
    logic                 rd_valid, rd_tag_en, rd_ivl;
    logic [NUM_PORTS-1:0] rd_members;
    logic [EGR_W-1:0]     rd_egress;
    logic                 vid_hit;
    logic [ADDR_W-1:0]    vid_off;
    logic [PAIR_W-1:0]    vid_pair;
    logic [2*VID_W-1:0]   vid_rdata;

    assign go = host_we && (host_addr == A_CMD) && host_wdata[VCT_GO_BIT];

    vct_ctrl #(.NUM_ENTRIES(NUM_ENTRIES), .BUSY_CYCLES(BUSY_CYCLES)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .go(go),
        .go_op(host_wdata[VCT_OP_LSB +: VCT_OP_W]),
        .go_idx(host_wdata[VCT_IDX_W-1:0]),
        .busy(busy), .op_q(op_q), .idx_q(idx_q), .idx_ok(idx_ok),
        .tbl_we(tbl_we), .dw_load(dw_load)
    );

    vct_store #(.NUM_ENTRIES(NUM_ENTRIES), .NUM_PORTS(NUM_PORTS)) u_store (
        .clk(clk), .rst_n(rst_n), .we(tbl_we), .wr_idx(idx_q[IDX_W-1:0]),
        .wr_valid(dwa_q[VCT_B_VALID]),
        .wr_members(dwa_q[VCT_B_MEMBERS +: NUM_PORTS]),
        .wr_tag_en(dwa_q[VCT_B_TAGEN]), .wr_ivl(dwa_q[VCT_B_IVL]),
        .wr_egress(dwb_q[EGR_W-1:0]), .rd_idx(idx_q[IDX_W-1:0]),
        .rd_valid(rd_valid), .rd_members(rd_members), .rd_tag_en(rd_tag_en),
        .rd_ivl(rd_ivl), .rd_egress(rd_egress), .lk_idx(lk_idx),
        .lk_valid(lk_valid), .lk_members(lk_members), .lk_tag_en(lk_tag_en),
        .lk_ivl(lk_ivl), .lk_egress(lk_egress)
    );

    always_comb begin
        vid_off  = host_addr - A_VID;
        vid_pair = vid_off[PAIR_W+1:2];
        vid_hit  = (host_addr >= A_VID) && (host_addr < A_VEND) && (host_addr[1:0] == 2'b00);
    end

    vct_vid_bank #(.NUM_ENTRIES(NUM_ENTRIES), .VID_W(VID_W)) u_vid (
        .clk(clk), .rst_n(rst_n), .we(host_we && vid_hit), .pair(vid_pair),
        .wdata(host_wdata[2*VID_W-1:0]), .rdata(vid_rdata),
        .lk_idx(lk_idx), .lk_vid(lk_vid)
    );

    always_comb begin
        rd_word_a                              = '0;
        rd_word_a[VCT_B_VALID]                 = rd_valid;
        rd_word_a[VCT_B_MEMBERS +: NUM_PORTS]  = rd_members;
        rd_word_a[VCT_B_TAGEN]                 = rd_tag_en;
        rd_word_a[VCT_B_IVL]                   = rd_ivl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dwa_q <= '0;
            dwb_q <= '0;
        end else if (dw_load) begin
            dwa_q <= idx_ok ? rd_word_a : '0;
            dwb_q <= idx_ok ? 32'(rd_egress) : '0;
        end else if (host_we) begin
            if (host_addr == A_DWA) dwa_q <= host_wdata;
            if (host_addr == A_DWB) dwb_q <= host_wdata;
        end
    end

    always_comb begin
        host_rdata = '0;
        if (host_addr == A_CMD) begin
            host_rdata[VCT_GO_BIT]                 = busy;
            host_rdata[VCT_OP_LSB +: VCT_OP_W]     = op_q;
            host_rdata[VCT_IDX_W-1:0]              = idx_q;
        end else if (host_addr == A_DWA) begin
            host_rdata = dwa_q;
        end else if (host_addr == A_DWB) begin
            host_rdata = dwb_q;
        end else if (vid_hit) begin
            host_rdata[2*VID_W-1:0] = vid_rdata;
        end
    end

    // R4
    read_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dw_load && idx_ok) |=> (dwa_q == $past(rd_word_a)));
    // R9
    oor_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dw_load && (idx_q >= VCT_IDX_W'(NUM_ENTRIES))) |=> (dwa_q == '0 && dwb_q == '0));
endmodule

// File: tb/sim_vlan_cmd_engine.sv
module sim_vlan_cmd_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [11:0] host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic [3:0]  lk_idx = '0;
    logic        lk_valid, lk_tag_en, lk_ivl;
    logic [7:0]  lk_members;
    logic [15:0] lk_egress;
    logic [11:0] lk_vid;

    int checks = 0;
    int errors = 0;

    vlan_cmd_engine u0 (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .lk_idx(lk_idx),
        .lk_valid(lk_valid), .lk_members(lk_members), .lk_tag_en(lk_tag_en),
        .lk_ivl(lk_ivl), .lk_egress(lk_egress), .lk_vid(lk_vid)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        host_addr = a;
        #1 d = host_rdata;
    endtask

    task automatic wait_idle(output int n);
        logic [31:0] r;
        n = 0;
        bus_read(12'h000, r);
        while (r[31]) begin
            n++;
            @(negedge clk);
            bus_read(12'h000, r);
        end
    endtask

    task automatic run_cmd(input logic [2:0] op, input logic [11:0] idx, output int n);
        bus_write(12'h000, 32'h8000_0000 | (32'(op) << 12) | 32'(idx));
        wait_idle(n);
    endtask

    task automatic look(input logic [3:0] e);
        lk_idx = e;
        #1;
    endtask

    task automatic t_reset;
        logic [31:0] r;
        for (int e = 0; e < 16; e++) begin
            look(4'(e));
            check(!lk_valid && lk_members == 0, "R10 entry invalid", {31'd0, lk_valid}, 0);
            check(lk_vid == 12'(e), "R10 vid equals index", 32'(lk_vid), e);
        end
        bus_read(12'h108, r);
        check(r == 32'h0000_5004, "R10 vid pair 2", r, 32'h0000_5004);
        bus_read(12'h000, r);
        check(r == 0, "R10 command idle", r, 0);
        bus_read(12'h004, r);
        check(r == 0, "R10 data word A", r, 0);
    endtask

    task automatic t_write_entry;
        int n;
        logic [31:0] r;
        bus_write(12'h004, 32'h50A5_0001);
        bus_write(12'h008, 32'h0000_E4E4);
        bus_write(12'h000, 32'h0000_1007);
        bus_read(12'h000, r);
        check(r[31] == 1'b0, "R1 no start without go bit", r, 0);
        bus_write(12'h000, 32'h8000_1003);
        bus_read(12'h000, r);
        check(r == 32'h8000_1003, "R2 busy readback", r, 32'h8000_1003);
        wait_idle(n);
        check(n == 4, "R1 busy length", n, 4);
        bus_read(12'h000, r);
        check(r == 32'h0000_1003, "R2 done readback", r, 32'h0000_1003);
        look(4'd3);
        check(lk_valid && lk_members == 8'hA5, "R3 members", 32'(lk_members), 32'hA5);
        check(lk_tag_en && lk_ivl, "R3 flags", {lk_tag_en, lk_ivl}, 3);
        check(lk_egress == 16'hE4E4, "R5 egress codes", 32'(lk_egress), 32'hE4E4);
        look(4'd7);
        check(!lk_valid, "R1 no-go entry untouched", {31'd0, lk_valid}, 0);
    endtask

    task automatic t_read_back;
        int n;
        logic [31:0] r;
        bus_write(12'h004, 32'hFFFF_FFFF);
        bus_write(12'h008, 32'hFFFF_1B1B);
        run_cmd(3'd1, 12'd5, n);
        bus_write(12'h004, 32'h0);
        bus_write(12'h008, 32'h0);
        run_cmd(3'd0, 12'd5, n);
        check(n == 4, "R1 read busy length", n, 4);
        bus_read(12'h004, r);
        check(r == 32'h50FF_0001, "R4 word A load", r, 32'h50FF_0001);
        bus_read(12'h008, r);
        check(r == 32'h0000_1B1B, "R5 word B load", r, 32'h0000_1B1B);
        run_cmd(3'd0, 12'd3, n);
        bus_read(12'h004, r);
        check(r == 32'h50A5_0001, "R4 entry 3 word A", r, 32'h50A5_0001);
    endtask

    task automatic t_invalidate;
        int n;
        bus_write(12'h004, 32'h0);
        bus_write(12'h008, 32'h0);
        run_cmd(3'd1, 12'd3, n);
        look(4'd3);
        check(!lk_valid && lk_members == 0, "R6 entry invalid", {23'd0, lk_members, lk_valid}, 0);
    endtask

    task automatic t_vid;
        logic [31:0] r;
        bus_write(12'h10C, 32'hFFAB_C123);
        look(4'd6);
        check(lk_vid == 12'h123, "R7 even vid", 32'(lk_vid), 32'h123);
        look(4'd7);
        check(lk_vid == 12'hABC, "R7 odd vid", 32'(lk_vid), 32'hABC);
        bus_read(12'h10C, r);
        check(r == 32'h00AB_C123, "R7 pair readback", r, 32'h00AB_C123);
        bus_read(12'h108, r);
        check(r == 32'h0000_5004, "R7 neighbour untouched", r, 32'h0000_5004);
    endtask

    task automatic t_busy_ignore;
        int n;
        logic [31:0] r;
        bus_write(12'h004, 32'h0011_0001);
        bus_write(12'h000, 32'h8000_1009);
        bus_write(12'h000, 32'h8000_100A);
        wait_idle(n);
        bus_read(12'h000, r);
        check(r == 32'h0000_1009, "R8 command unchanged", r, 32'h0000_1009);
        look(4'd10);
        check(!lk_valid, "R8 second entry untouched", {31'd0, lk_valid}, 0);
        look(4'd9);
        check(lk_valid && lk_members == 8'h11, "R8 first op done", 32'(lk_members), 32'h11);
    endtask

    task automatic t_out_of_range;
        int n;
        logic [31:0] r;
        bus_write(12'h004, 32'h00FF_0001);
        run_cmd(3'd1, 12'd20, n);
        check(n == 4, "R9 busy length", n, 4);
        look(4'd4);
        check(!lk_valid, "R9 aliased entry untouched", {31'd0, lk_valid}, 0);
        bus_write(12'h008, 32'h1234);
        run_cmd(3'd0, 12'd17, n);
        bus_read(12'h004, r);
        check(r == 0, "R9 word A zero", r, 0);
        bus_read(12'h008, r);
        check(r == 0, "R9 word B zero", r, 0);
    endtask

    task automatic t_bad_op;
        int n;
        logic [31:0] r;
        bus_write(12'h004, 32'h0055_0001);
        bus_write(12'h008, 32'h0000_0003);
        run_cmd(3'd3, 12'd3, n);
        check(n == 4, "R11 busy length", n, 4);
        bus_read(12'h004, r);
        check(r == 32'h0055_0001, "R11 word A kept", r, 32'h0055_0001);
        bus_read(12'h008, r);
        check(r == 32'h3, "R11 word B kept", r, 32'h3);
        look(4'd3);
        check(!lk_valid, "R11 entry unchanged", {31'd0, lk_valid}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write_entry();
        t_read_back();
        t_invalidate();
        t_vid();
        t_busy_ignore();
        t_out_of_range();
        t_bad_op();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule